// File: doc/BRIEF.md
# Read-Gate Calibration Sequencer with Refresh Make-Up

This block runs the read-strobe gate calibration on a memory PHY with two byte lanes. When asked to start, it records the controller's current refresh-interval setting and then writes zero to that setting. A zero interval stops auto-refresh. The block then raises the calibration start bit and waits for both lanes to report completion.

Calibration takes roughly two and a half refresh periods. After calibration ends, the block issues a fixed burst of refresh commands through a request/acknowledge handshake. It then writes the recorded interval back, and only then reports done. If the lanes do not both finish within a set number of cycles, the block gives up and raises an error flag. It still makes up the refreshes and still restores the interval.

Top module: `dqs_gate_trainer`

## Requirements
- R1: A start request seen while idle captures `ivl_rd_i` and writes zero to the interval register in the following cycle (one `ivl_we_o` pulse with `ivl_wd_o` = 0). `cal_ctrl_o` becomes 2'b01 in the cycle after that write. Bit 1 of `cal_ctrl_o` is always 0.
- R2: For the first SETTLE_CYC cycles after `cal_ctrl_o` bit 0 rises, `lane_done_i` is ignored. Bit 0 therefore stays high for at least SETTLE_CYC+1 cycles.
- R3: After the settle delay, calibration ends (`cal_ctrl_o` returns to 2'b00) on the first clock edge that sees both `lane_done_i[1]` (upper lane) and `lane_done_i[0]` (lower lane) high together. One lane alone never ends it.
- R4: Once calibration ends, exactly NUM_REF (3) refresh commands are issued. Each command is one cycle with `ref_req_o` and `ref_ack_i` both high. `ref_req_o` stays high while `ref_ack_i` is low. `ref_req_o` is never high while calibration runs.
- R5: In the cycle after the last refresh handshake, the block makes exactly one write of the captured value and pulses `done_o` for one cycle in that same cycle. It is idle (`busy_o` low) at that point.
- R6: If both lanes are not seen together within TIMEOUT_CYC polling cycles, calibration ends after SETTLE_CYC+TIMEOUT_CYC cycles of `cal_ctrl_o` bit 0 and `err_o` is set. The refreshes and the restore still follow.
- R7: `err_o` holds its value while idle and is cleared by the next accepted start.
- R8: A start request while busy is ignored. A run makes exactly two interval writes.
- R9: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run calibration |
| ivl_rd_i | input | DW | Current refresh-interval register value |
| ivl_we_o | output | 1 | Interval register write strobe |
| ivl_wd_o | output | DW | Interval register write data |
| cal_ctrl_o | output | 2 | Calibration control; 2'b01 runs, 2'b00 stops |
| lane_done_i | input | 2 | Per-lane calibration done; bit 1 upper, bit 0 lower |
| ref_req_o | output | 1 | Refresh command request |
| ref_ack_i | input | 1 | Refresh command accepted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the interval is restored |
| err_o | output | 1 | Last run timed out waiting for lanes |

## Verification
A wrong state or counter shows up at the ports as a change in how long `cal_ctrl_o` bit 0 stays high. Every run predicts that length exactly: SETTLE_CYC+1 when the lanes are ready early, the lane arrival time when they arrive later, and SETTLE_CYC+TIMEOUT_CYC on timeout. A settle or poll counter that is off by one shows up in the first run. A broken refresh counter changes the number of handshakes seen before the restore write. A lost capture register shows up as wrong data on that write, which happens a few cycles after calibration ends.

// File: rtl/dqs_gate_trainer.sv
module dqs_gate_trainer #(
  parameter int DW          = 16,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int NUM_REF     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] ivl_rd_i,
  output logic          ivl_we_o,
  output logic [DW-1:0] ivl_wd_o,
  output logic [1:0]    cal_ctrl_o,
  input  logic [1:0]    lane_done_i,
  output logic          ref_req_o,
  input  logic          ref_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int CMAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(NUM_REF + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETTLE, S_POLL, S_REF} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [DW-1:0] saved;
  logic          cal_on;

  assign cal_ctrl_o = {1'b0, cal_on};
  assign ref_req_o  = (st == S_REF);
  assign busy_o     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rcnt     <= '0;
      saved    <= '0;
      cal_on   <= 1'b0;
      ivl_we_o <= 1'b0;
      ivl_wd_o <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      ivl_we_o <= 1'b0;
      done_o   <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          saved    <= ivl_rd_i;
          ivl_we_o <= 1'b1;
          ivl_wd_o <= '0;
          err_o    <= 1'b0;
          st       <= S_ARM;
        end
        S_ARM: begin
          cal_on <= 1'b1;
          cnt    <= '0;
          st     <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_POLL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POLL: begin
          if (lane_done_i == 2'b11) begin
            cal_on <= 1'b0;
            rcnt   <= '0;
            st     <= S_REF;
          end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
            cal_on <= 1'b0;
            err_o  <= 1'b1;
            rcnt   <= '0;
            st     <= S_REF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REF: if (ref_ack_i) begin
          if (rcnt == RW'(NUM_REF - 1)) begin
            ivl_we_o <= 1'b1;
            ivl_wd_o <= saved;
            done_o   <= 1'b1;
            st       <= S_IDLE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dqs_gate_trainer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ivl_we_o,
  input logic [DW-1:0] ivl_wd_o,
  input logic [1:0]    cal_ctrl_o,
  input logic          ref_req_o,
  input logic          ref_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  a_r1_zero_before_cal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ctrl_o[0]) |-> $past(ivl_we_o && ivl_wd_o == '0));
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);
  a_r4_no_ref_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ctrl_o[0] |-> !ref_req_o);
  a_r5_done_with_restore: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ivl_we_o && !busy_o));
  a_r6_err_at_cal_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $fell(cal_ctrl_o[0]));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind dqs_gate_trainer dqs_gate_trainer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ivl_we_o(ivl_we_o), .ivl_wd_o(ivl_wd_o),
  .cal_ctrl_o(cal_ctrl_o), .ref_req_o(ref_req_o), .ref_ack_i(ref_ack_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

// File: tb/dqs_gate_trainer_tb.sv
module dqs_gate_trainer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int S  = 4;
  localparam int T  = 64;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ref_ack_i = 1'b0;
  logic [DW-1:0] ivl_rd_i = '0;
  logic [1:0] lane_done_i = '0;
  logic ivl_we_o, ref_req_o, busy_o, done_o, err_o;
  logic [DW-1:0] ivl_wd_o;
  logic [1:0] cal_ctrl_o;

  int checks = 0, fails = 0, cyc = 0;
  logic last_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dqs_gate_trainer #(.DW(DW), .SETTLE_CYC(S), .TIMEOUT_CYC(T), .NUM_REF(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ivl_rd_i(ivl_rd_i),
    .ivl_we_o(ivl_we_o), .ivl_wd_o(ivl_wd_o), .cal_ctrl_o(cal_ctrl_o),
    .lane_done_i(lane_done_i), .ref_req_o(ref_req_o), .ref_ack_i(ref_ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cal(input int d, input logic [1:0] p);
    int m = (d > S + 1) ? d : S + 1;
    if (p == 2'b11 && m <= S + T) return m;
    return S + T;
  endfunction

  function automatic logic exp_err(input int d, input logic [1:0] p);
    return exp_cal(d, p) == S + T && !(p == 2'b11 && d == S + T);
  endfunction

  task automatic run(input int d, input logic [1:0] pat, input bit hold);
    logic [DW-1:0] val = DW'($urandom);
    int zeros = 0, restores = 0, zero_at = -1, rise_at = -1, cal_n = 0;
    int hs = 0, hs_at_restore = -1, dones = 0, bit1 = 0, overlap = 0;
    logic [DW-1:0] rdata = '0;
    bit finished = 0;
    logic err_after_start = 1'b1;
    check("R7 err held while idle", err_o, last_err);
    ivl_rd_i = val;
    start_i  = 1'b1;
    for (int n = 1; n < 400 && !finished; n++) begin
      @(negedge clk);
      ivl_rd_i = DW'($urandom);
      start_i  = hold && n < 6;
      if (n == 1) err_after_start = err_o;
      if (ivl_we_o) begin
        if (ivl_wd_o == '0 && zeros == 0 && restores == 0) begin zeros++; zero_at = n; end
        else begin restores++; rdata = ivl_wd_o; hs_at_restore = hs; end
      end
      if (cal_ctrl_o[1]) bit1++;
      if (cal_ctrl_o[0] && ref_req_o) overlap++;
      if (cal_ctrl_o[0]) begin
        if (rise_at < 0) rise_at = n;
        cal_n++;
      end
      if (done_o) begin
        dones++;
        check("R5 idle at done", busy_o, 0);
        finished = 1;
      end
      lane_done_i = cal_ctrl_o[0] ? ((cal_n >= d) ? pat : 2'b00) : 2'($urandom);
      ref_ack_i   = ($urandom_range(0, 1) == 1);
      if (ref_req_o && ref_ack_i) hs++;
    end
    @(negedge clk);
    ref_ack_i = 1'b0;
    if (ivl_we_o) restores++;
    check("R1 zero write first", zero_at, 1);
    check("R1 cal starts after zero write", rise_at, 2);
    check("R1 cal bit1 never set", bit1, 0);
    check("R2/R3/R6 calibration length", cal_n, exp_cal(d, pat));
    check("R6 error flag", err_o, exp_err(d, pat));
    check("R7 err cleared at start", err_after_start, 0);
    check("R4 three refreshes before restore", hs_at_restore, 3);
    check("R4 no refresh after restore", hs, 3);
    check("R4 no refresh during cal", overlap, 0);
    check("R5 restored value", rdata, val);
    check("R5 one done pulse", dones, 1);
    check("R8 exactly two writes", zeros + restores, 2);
    last_err = err_o;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset we", ivl_we_o, 0);
    check("R9 reset cal", cal_ctrl_o, 0);
    check("R9 reset req/busy/done/err", {ref_req_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1, 2'b11, 0);
    run(10, 2'b11, 0);
    run(1, 2'b01, 0);
    run(3, 2'b10, 1);
    run(100, 2'b11, 0);
    run(S + 1, 2'b11, 1);
    run(S + T, 2'b11, 0);
    for (int k = 0; k < 20; k++)
      run($urandom_range(1, 80), 2'($urandom), $urandom_range(0, 1) == 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected finish", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule